// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt sources of a graphics engine and gives the host a single active-high interrupt line. Two sources are completion events: a binner flush-done event and a render frame-done event. Each arrives as a one-cycle pulse and is held in a status bit until the host acknowledges it. The third source is a binner out-of-memory condition. It is a level: its status bit stays set for as long as the binner has no overflow memory pool.

The host reaches the block through a plain register bus. The write port is a strobe with an address and data. The read data follows the address combinationally. The enable mask has no register of its own to write. Instead, one register sets mask bits and another clears them, and reading either one returns the mask. The controller also holds the overflow pool base address and size. After reset the pool is empty, so the out-of-memory condition is present. Once the host has written both the base and the size, the condition goes away, and a later acknowledge clears the bit. A pulse from the engine marks the pool as used up, and the condition returns.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: While reset is held, the status, the enable mask, both pool registers and `irq` read 0. On the first clock edge after reset is released, the status reads 0x1, because the pool starts empty.
- R2: Status sits at offset 0x0. Writing 1 to bit 1 or bit 2 there clears that bit on the next edge. A 0 in the written data leaves the corresponding bit as it is.
- R3: If a done pulse and a write-1 clear hit the same status bit in the same cycle, the bit is set after the edge.
- R4: A write to offset 0x4 sets every mask bit written as 1. Mask bits written as 0 keep their value.
- R5: A write to offset 0x8 clears every mask bit written as 1. Mask bits written as 0 keep their value.
- R6: Reading offset 0x4 or offset 0x8 returns the enable mask in bits 2:0, with all upper bits 0.
- R7: While the pool is empty, status bit 0 is set on every edge, and a write-1 to it has no effect.
- R8: The pool base sits at offset 0xC and the pool size at offset 0x10. Both read back what was last written. Once both have been written while the pool is empty, the pool becomes valid, and from the next edge onward an acknowledge of bit 0 clears it.
- R9: A one-cycle `pool_exhausted` pulse makes the pool empty again. The pulse takes priority over a pool register write in the same cycle, and both pool registers must then be written again.
- R10: `irq` is registered. It equals the OR over all bits of status AND mask, as those values stood one edge earlier.
- R11: The status bits are out-of-memory in bit 0, flush-done in bit 1 and frame-done in bit 2. Any address other than the five offsets listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address used for both reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| flush_done_pulse | input | 1 | Binner flush-done event, one cycle |
| frame_done_pulse | input | 1 | Render frame-done event, one cycle |
| pool_exhausted | input | 1 | The engine has used up the overflow pool |
| irq | output | 1 | Combined interrupt to the host, active high |

## Verification
The bench uses the default parameters: a 5-bit address and 32-bit data. With a 5-bit address every offset can be reached, including the unmapped ones above 0x10, so random traffic lands on the status, the two mask registers, the pool registers and the unmapped space at similar rates. Random event pulses and exhaustion pulses hit the status bits in the same cycles as acknowledges. This covers the set-wins collision and the re-arming of the pool, alongside directed sequences through the out-of-memory handshake.

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              flush_done_pulse,
  input  logic              frame_done_pulse,
  input  logic              pool_exhausted,
  output logic              irq
);
  localparam int NSRC = 3;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(5'h10);

  logic [NSRC-1:0]   status_q, mask_q, raise;
  logic [DATA_W-1:0] base_q, size_q;
  logic              pool_empty_q, got_base_q, got_size_q;
  logic              wr_stat, wr_eset, wr_eclr, wr_base, wr_size;
  logic              base_seen, size_seen;

  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign wr_eset = reg_wr && reg_addr == A_ESET;
  assign wr_eclr = reg_wr && reg_addr == A_ECLR;
  assign wr_base = reg_wr && reg_addr == A_BASE;
  assign wr_size = reg_wr && reg_addr == A_SIZE;

  assign raise     = {frame_done_pulse, flush_done_pulse, pool_empty_q};
  assign base_seen = got_base_q | wr_base;
  assign size_seen = got_size_q | wr_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= raise | (status_q & ~(wr_stat ? reg_wdata[NSRC-1:0] : '0));
      if (wr_eset) mask_q <= mask_q | reg_wdata[NSRC-1:0];
      else if (wr_eclr) mask_q <= mask_q & ~reg_wdata[NSRC-1:0];
      irq <= |(status_q & mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q       <= '0;
      size_q       <= '0;
      pool_empty_q <= 1'b1;
      got_base_q   <= 1'b0;
      got_size_q   <= 1'b0;
    end else begin
      if (wr_base) base_q <= reg_wdata;
      if (wr_size) size_q <= reg_wdata;
      if (pool_exhausted) begin
        pool_empty_q <= 1'b1;
        got_base_q   <= 1'b0;
        got_size_q   <= 1'b0;
      end else if (pool_empty_q) begin
        if (base_seen && size_seen) begin
          pool_empty_q <= 1'b0;
          got_base_q   <= 1'b0;
          got_size_q   <= 1'b0;
        end else begin
          got_base_q <= base_seen;
          got_size_q <= size_seen;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:         reg_rdata[NSRC-1:0] = status_q;
      A_ESET, A_ECLR: reg_rdata[NSRC-1:0] = mask_q;
      A_BASE:         reg_rdata = base_q;
      A_SIZE:         reg_rdata = size_q;
      default:        reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              flush_done_pulse,
  input logic              frame_done_pulse,
  input logic              pool_exhausted,
  input logic [2:0]        status_q,
  input logic [2:0]        mask_q,
  input logic              pool_empty_q,
  input logic              irq
);
  logic w_stat, w_eset, w_eclr;
  assign w_stat = reg_wr && reg_addr == ADDR_W'(5'h00);
  assign w_eset = reg_wr && reg_addr == ADDR_W'(5'h04);
  assign w_eclr = reg_wr && reg_addr == ADDR_W'(5'h08);

  assert_ack_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && reg_wdata[1] && !flush_done_pulse) |=> !status_q[1]);
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_pulse |=> status_q[2]);
  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_eset |=> ((mask_q & $past(reg_wdata[2:0])) == $past(reg_wdata[2:0])));
  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_eclr |=> ((mask_q & $past(reg_wdata[2:0])) == 3'b000));
  assert_oom_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty_q |=> status_q[0]);
  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pool_exhausted |=> pool_empty_q);
  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(|(status_q & mask_q))));
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .flush_done_pulse(flush_done_pulse),
  .frame_done_pulse(frame_done_pulse), .pool_exhausted(pool_exhausted),
  .status_q(status_q), .mask_q(mask_q), .pool_empty_q(pool_empty_q), .irq(irq));

// File: tb/gfx_irq_ctrl_bench.sv
module gfx_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        flush_done_pulse = 1'b0, frame_done_pulse = 1'b0, pool_exhausted = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  logic [2:0]  m_st, m_mk;
  logic [31:0] m_base, m_size;
  logic        m_empty, m_gb, m_gs, m_irq;

  always #4 clk = ~clk;

  gfx_irq_ctrl u_gfx_irq_ctrl (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flush_done_pulse(flush_done_pulse), .frame_done_pulse(frame_done_pulse),
    .pool_exhausted(pool_exhausted), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a)
      5'h00: return {29'd0, m_st};
      5'h04, 5'h08: return {29'd0, m_mk};
      5'h0C: return m_base;
      5'h10: return m_size;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h00: return "R2 status";
      5'h04, 5'h08: return "R6 mask";
      5'h0C, 5'h10: return "R8 pool";
      default: return "R11 unmapped";
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_mk = 0; m_base = 0; m_size = 0;
    m_empty = 1; m_gb = 0; m_gs = 0; m_irq = 0;
  endtask

  task automatic model_edge();
    logic [2:0] clr;
    logic wb, ws;
    clr = (reg_wr && reg_addr == 5'h00) ? reg_wdata[2:0] : 3'b000;
    wb = reg_wr && reg_addr == 5'h0C;
    ws = reg_wr && reg_addr == 5'h10;
    m_irq = |(m_st & m_mk);
    m_st = {frame_done_pulse, flush_done_pulse, m_empty} | (m_st & ~clr);
    if (reg_wr && reg_addr == 5'h04) m_mk = m_mk | reg_wdata[2:0];
    if (reg_wr && reg_addr == 5'h08) m_mk = m_mk & ~reg_wdata[2:0];
    if (wb) m_base = reg_wdata;
    if (ws) m_size = reg_wdata;
    if (pool_exhausted) begin
      m_empty = 1; m_gb = 0; m_gs = 0;
    end else if (m_empty) begin
      if ((m_gb | wb) && (m_gs | ws)) begin
        m_empty = 0; m_gb = 0; m_gs = 0;
      end else begin
        m_gb = m_gb | wb; m_gs = m_gs | ws;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    reg_wr = 0; flush_done_pulse = 0; frame_done_pulse = 0; pool_exhausted = 0;
    check("R10 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    repeat (3) @(negedge clk);
    rd("R1 status", 5'h00, 0);
    rd("R1 mask", 5'h04, 0);
    rd("R1 base", 5'h0C, 0);
    rd("R1 size", 5'h10, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rst_n = 1;
    step();
    rd("R1 oom after reset", 5'h00, 32'h1);
    wr(5'h00, 32'h1);
    rd("R7 ack ignored while empty", 5'h00, 32'h1);
    wr(5'h04, 32'h5);
    rd("R4 mask set", 5'h04, 32'h5);
    rd("R6 read via clear reg", 5'h08, 32'h5);
    step();
    check("R10 irq high", {31'd0, irq}, 1);
    wr(5'h08, 32'hFFFF_FFF9);
    rd("R5 mask clear", 5'h04, 32'h4);
    wr(5'h04, 32'h0);
    rd("R4 zero write ignored", 5'h04, 32'h4);
    flush_done_pulse = 1; reg_wr = 1; reg_addr = 5'h00; reg_wdata = 32'h2;
    step();
    rd("R3 set wins", 5'h00, 32'h3);
    wr(5'h00, 32'h0);
    rd("R2 zero write keeps", 5'h00, 32'h3);
    wr(5'h00, 32'h2);
    rd("R2 ack clears flush", 5'h00, 32'h1);
    wr(5'h0C, 32'hCAFE_0000);
    wr(5'h00, 32'h1);
    rd("R7 base only not enough", 5'h00, 32'h1);
    wr(5'h10, 32'h0004_0000);
    wr(5'h00, 32'h1);
    rd("R8 ack clears oom", 5'h00, 32'h0);
    rd("R8 base readback", 5'h0C, 32'hCAFE_0000);
    rd("R8 size readback", 5'h10, 32'h0004_0000);
    frame_done_pulse = 1;
    step();
    rd("R11 frame bit 2", 5'h00, 32'h4);
    pool_exhausted = 1; reg_wr = 1; reg_addr = 5'h0C; reg_wdata = 32'h1234;
    step();
    step();
    rd("R9 oom re-armed", 5'h00, 32'h5);
    rd("R11 unmapped", 5'h14, 32'h0);
    rd("R11 unmapped top", 5'h1C, 32'h0);
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom;
      flush_done_pulse = (r[3:0] == 0);
      frame_done_pulse = (r[7:4] == 1);
      pool_exhausted   = (r[13:8] == 2);
      reg_wr    = r[16];
      reg_addr  = 5'($urandom_range(0, 24)) & 5'h1C;
      if (r[17]) reg_addr = 5'($urandom);
      reg_wdata = $urandom;
      step();
      begin
        logic [4:0] a;
        a = 5'($urandom);
        rd(tag_of(a), a, exp_read(a));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule